// File: doc/BRIEF.md
# Random-Number Register Interface

This block is the register front end of a memory-mapped random-number peripheral. A raw entropy word arrives on an input port every clock. When generation is enabled, a sampler takes one raw word every 2^k clocks, where k is a programmable divider exponent. A stateless mixing stage conditions each sample, and the result is pushed into a four-word output FIFO. Software reads words from a data register. A data-ready flag and an interrupt line signal that a word can be read.

The configuration fields take effect only through a conditioning reset. Software writes the control register with the reset bit set and the new configuration in the same access. A second write with the bit clear then starts a fixed internal cycle. During that cycle the reset bit still reads 1, the FIFO is flushed and no data is offered. The cycle also clears a standing seed error.

A seed error is injected through a test input, in one of two forms. In the first form the peripheral recovers by itself: the current flag clears and the interrupt flag stays set. In the second form the current flag stays set until software runs a conditioning reset. A clock-error input is honoured only while detection is enabled.

Top module: `rng_regif`

## Requirements
- R1: After reset the control and status registers read 0, data_ready and irq are low, and the version register (offset 0x3F4) reads major revision in bits 7:4 and minor revision in bits 3:0 (defaults 2 and 1, so 0x21). Offsets are: control 0x000, status 0x004, data 0x008, noise control 0x00C, health control 0x010.
- R2: data_ready is high exactly when the FIFO holds a word, enable (control bit 2) is set and no conditioning reset is pending or running. Each read of the data register pops one word. Each word equals M(raw, c), where t = raw ^ rotl(raw,7) ^ (c << 18) ^ 0x9E3779B9 and c = {ctrl[25:20], ctrl[15:8]} as latched. A t of 0 is replaced by 1.
- R3: The FIFO holds four words and returns them in arrival order. Sampling pauses while the FIFO is full.
- R4: The configuration fields latch only from a control write that also sets bit 30. These fields are bits 25:20 and 15:8, the divider exponent in bits 19:16 and clock-error detect in bit 5. A control write with bit 30 clear leaves them unchanged. Enable and interrupt enable (bit 3) are written by every control write.
- R5: Writing bit 30 as 1 and then as 0 starts a 16-clock cycle. Bit 30 reads 1 from the first write until the cycle ends. During that time data_ready is low and the FIFO is left empty.
- R6: A seed error injected with seed_fault_auto low sets status bit 2 (current) and bit 6 (interrupt) and flushes the FIFO. Generation stops. Bit 2 stays set until a software conditioning reset completes.
- R7: A seed error injected with seed_fault_auto high runs the 16-clock cycle on its own, without bit 30 reading 1. Bit 2 then clears, bit 6 stays set, and generation resumes.
- R8: A data-register read while no word is offered returns 0 and pops nothing.
- R9: With clock-error detect latched as 1, status bit 1 follows clk_fault_inj one clock later, and status bit 5 sets on its rise. Generation stops while bit 1 is set. With detection latched as 0, clk_fault_inj has no effect.
- R10: Writing 0 to status bit 5 or 6 clears it, and writing 1 leaves it unchanged. Status bits 0, 1 and 2 ignore writes.
- R11: irq is high exactly when interrupt enable (control bit 3) is set and status bit 5 or bit 6 is set.
- R12: With divider exponent k, the first word after generation becomes active is pushed on the 2^k-th clock.
- R13: The noise control register keeps bits 17:0 and reads 0 above them. The health control register keeps all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Register byte address |
| bus_wr | input | 1 | Write strobe, one access per clock |
| bus_rd | input | 1 | Read strobe (pops the data register) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| entropy_in | input | 32 | Raw entropy word |
| seed_fault_inj | input | 1 | Seed error injection, one pulse per error |
| seed_fault_auto | input | 1 | Selects self-recovering seed error |
| clk_fault_inj | input | 1 | Clock error level |
| data_ready | output | 1 | A word can be read |
| irq | output | 1 | Interrupt request |

## Verification
The bench holds the raw entropy at one constant and then switches it to a second constant. The output order then shows whether the FIFO really holds four words and keeps arrival order. Writing a second configuration without the reset bit, and then with it, shows whether the fields are ignored or applied. The check uses both the control readback and the conditioned word values. The two seed-error forms are told apart by their status signatures and by whether bit 30 reads 1. A non-zero divider exponent is timed to the exact clock of the first word.

// File: rtl/rng_pkg.sv
package rng_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned CFG_W  = 14;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_DATA   = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_NOISE  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_HEALTH = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_VER    = 12'h3F4;

  localparam int B_EN   = 2;
  localparam int B_IE   = 3;
  localparam int B_CED  = 5;
  localparam int B_CRST = 30;
  localparam int B_DRDY = 0;
  localparam int B_CECS = 1;
  localparam int B_SECS = 2;
  localparam int B_CEIS = 5;
  localparam int B_SEIS = 6;

  localparam int unsigned NOISE_W = 18;
  localparam logic [WORD_W-1:0] MIX_CONST = 32'h9E37_79B9;

  // configuration fields gathered into one vector
  function automatic logic [CFG_W-1:0] cfg_pick(input logic [WORD_W-1:0] w);
    return {w[25:20], w[15:8]};
  endfunction

  // conditioning: stateless mix; zero is reserved for the error read
  function automatic logic [WORD_W-1:0] mix_word(input logic [WORD_W-1:0] raw,
                                                 input logic [CFG_W-1:0]  cfg);
    logic [WORD_W-1:0] t;
    t = raw ^ {raw[24:0], raw[31:25]} ^ {cfg, 18'h0} ^ MIX_CONST;
    return (t == '0) ? 32'h0000_0001 : t;
  endfunction
endpackage

// File: rtl/rng_fifo.sv
module rng_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 32,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic             empty,
  output logic             full,
  output logic [CNT_W-1:0] count
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic             do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign do_push = push & ~full & ~clr;
  assign do_pop  = pop & ~empty & ~clr;
  assign dout    = mem[rp];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end
endmodule

// File: rtl/rng_sampler.sv
module rng_sampler
  import rng_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [3:0]        div_exp,
  input  logic [WORD_W-1:0] raw,
  input  logic [CFG_W-1:0]  cfg,
  output logic              tick,
  output logic [WORD_W-1:0] word
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] limit;

  assign limit = (DIV_W'(1) << div_exp) - 1'b1;
  assign tick  = active & (cnt == limit);
  assign word  = mix_word(raw, cfg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!active || tick)  cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rng_condrst.sv
module rng_condrst #(
  parameter int unsigned CYCLES = 16,
  localparam int unsigned CNT_W = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  logic [CNT_W-1:0] cnt;

  assign busy = (cnt != '0);
  assign done = (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (start && !busy) cnt <= CNT_W'(CYCLES);
    else if (busy)           cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/rng_regif.sv
module rng_regif
  import rng_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned RST_CYCLES = 16,
  parameter int unsigned DIV_W      = 16,
  parameter logic [3:0]  VER_MAJOR  = 4'd2,
  parameter logic [3:0]  VER_MINOR  = 4'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [WORD_W-1:0] entropy_in,
  input  logic              seed_fault_inj,
  input  logic              seed_fault_auto,
  input  logic              clk_fault_inj,
  output logic              data_ready,
  output logic              irq
);
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1);

  logic             ctl_en, ctl_ie, ctl_ced;
  logic [CFG_W-1:0] ctl_cfg;
  logic [3:0]       ctl_div;
  logic             crst_req, auto_run;
  logic             secs, seis, cecs, ceis;
  logic [NOISE_W-1:0] noise_q;
  logic [WORD_W-1:0]  health_q;

  logic wr_ctrl, wr_stat, rd_data;
  logic crst_set, crst_go, auto_go, cr_start;
  logic rst_busy, rst_done;
  logic seed_evt, cecs_nx;
  logic gen_active, gen_tick, fifo_clr, word_vis, fifo_pop;
  logic [WORD_W-1:0] gen_word, fifo_dout;
  logic fifo_empty, fifo_full;
  logic [CNT_W-1:0] fifo_cnt;
  logic [WORD_W-1:0] ctrl_rd, stat_rd;

  assign wr_ctrl  = bus_wr & (bus_addr == OFS_CTRL);
  assign wr_stat  = bus_wr & (bus_addr == OFS_STAT);
  assign rd_data  = bus_rd & (bus_addr == OFS_DATA);
  assign seed_evt = seed_fault_inj;
  assign crst_set = wr_ctrl & bus_wdata[B_CRST];
  assign crst_go  = wr_ctrl & ~bus_wdata[B_CRST] & crst_req & ~rst_busy;
  assign auto_go  = seed_evt & seed_fault_auto & ~rst_busy & ~crst_req & ~crst_go;
  assign cr_start = crst_go | auto_go;
  assign cecs_nx  = clk_fault_inj & ctl_ced;

  assign fifo_clr   = seed_evt | crst_req | rst_busy;
  assign gen_active = ctl_en & ~secs & ~cecs & ~fifo_full & ~fifo_clr;
  assign word_vis   = ~fifo_empty & ~crst_req & ~rst_busy;
  assign fifo_pop   = rd_data & word_vis;
  assign data_ready = word_vis & ctl_en;
  assign irq        = ctl_ie & (seis | ceis);

  rng_sampler #(.DIV_W(DIV_W)) u_sampler (
    .clk(clk), .rst_n(rst_n), .active(gen_active), .div_exp(ctl_div),
    .raw(entropy_in), .cfg(ctl_cfg), .tick(gen_tick), .word(gen_word)
  );

  rng_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .push(gen_tick), .din(gen_word),
    .pop(fifo_pop), .dout(fifo_dout), .empty(fifo_empty), .full(fifo_full),
    .count(fifo_cnt)
  );

  rng_condrst #(.CYCLES(RST_CYCLES)) u_condrst (
    .clk(clk), .rst_n(rst_n), .start(cr_start), .busy(rst_busy), .done(rst_done)
  );

  // control register: config fields only through the reset-request write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en <= 1'b0; ctl_ie <= 1'b0; ctl_ced <= 1'b0;
      ctl_cfg <= '0; ctl_div <= '0; crst_req <= 1'b0; auto_run <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctl_en <= bus_wdata[B_EN];
        ctl_ie <= bus_wdata[B_IE];
      end
      if (crst_set) begin
        ctl_cfg  <= cfg_pick(bus_wdata);
        ctl_div  <= bus_wdata[19:16];
        ctl_ced  <= bus_wdata[B_CED];
        crst_req <= 1'b1;
      end else if (crst_go) begin
        crst_req <= 1'b0;
      end
      if (auto_go)               auto_run <= 1'b1;
      else if (crst_go || rst_done) auto_run <= 1'b0;
    end
  end

  // status flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secs <= 1'b0; seis <= 1'b0; cecs <= 1'b0; ceis <= 1'b0;
    end else begin
      if (seed_evt)      secs <= 1'b1;
      else if (rst_done) secs <= 1'b0;
      if (seed_evt)                          seis <= 1'b1;
      else if (wr_stat && !bus_wdata[B_SEIS]) seis <= 1'b0;
      cecs <= cecs_nx;
      if (cecs_nx && !cecs)                  ceis <= 1'b1;
      else if (wr_stat && !bus_wdata[B_CEIS]) ceis <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      noise_q <= '0; health_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == OFS_NOISE)  noise_q  <= bus_wdata[NOISE_W-1:0];
      if (bus_addr == OFS_HEALTH) health_q <= bus_wdata;
    end
  end

  always_comb begin
    ctrl_rd          = '0;
    ctrl_rd[B_EN]    = ctl_en;
    ctrl_rd[B_IE]    = ctl_ie;
    ctrl_rd[B_CED]   = ctl_ced;
    ctrl_rd[15:8]    = ctl_cfg[7:0];
    ctrl_rd[19:16]   = ctl_div;
    ctrl_rd[25:20]   = ctl_cfg[13:8];
    ctrl_rd[B_CRST]  = crst_req | (rst_busy & ~auto_run);
    stat_rd          = '0;
    stat_rd[B_DRDY]  = data_ready;
    stat_rd[B_CECS]  = cecs;
    stat_rd[B_SECS]  = secs;
    stat_rd[B_CEIS]  = ceis;
    stat_rd[B_SEIS]  = seis;
  end

  always_comb begin
    unique case (bus_addr)
      OFS_CTRL:   bus_rdata = ctrl_rd;
      OFS_STAT:   bus_rdata = stat_rd;
      OFS_DATA:   bus_rdata = word_vis ? fifo_dout : '0;
      OFS_NOISE:  bus_rdata = {{(WORD_W-NOISE_W){1'b0}}, noise_q};
      OFS_HEALTH: bus_rdata = health_q;
      OFS_VER:    bus_rdata = {24'h0, VER_MAJOR, VER_MINOR};
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rng_regif_chk.sv
module rng_regif_chk #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             data_ready,
  input logic             irq,
  input logic             ctl_en,
  input logic             ctl_ie,
  input logic             rst_busy,
  input logic             seed_evt,
  input logic             secs,
  input logic             seis,
  input logic             wr_stat,
  input logic             wdata_seis,
  input logic [CNT_W-1:0] fifo_cnt
);
  p_drdy_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |-> ctl_en);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CNT_W'(DEPTH));
  p_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_busy |=> (fifo_cnt == '0));
  p_seed_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    seed_evt |=> (secs && seis && fifo_cnt == '0));
  p_seis_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (seis && !(wr_stat && !wdata_seis)) |=> seis);
  p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctl_ie);
endmodule

bind rng_regif rng_regif_chk #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .data_ready(data_ready), .irq(irq),
  .ctl_en(ctl_en), .ctl_ie(ctl_ie), .rst_busy(rst_busy), .seed_evt(seed_evt),
  .secs(secs), .seis(seis), .wr_stat(wr_stat), .wdata_seis(bus_wdata[6]),
  .fifo_cnt(fifo_cnt)
);

// File: tb/rng_regif_bench.sv
`timescale 1ns/1ps
module rng_regif_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] entropy_in = '0;
  logic        seed_fault_inj = 1'b0, seed_fault_auto = 1'b0, clk_fault_inj = 1'b0;
  logic        data_ready, irq;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  localparam logic [11:0] A_CTRL = 12'h000, A_STAT = 12'h004, A_DATA = 12'h008,
                          A_NOISE = 12'h00C, A_HEALTH = 12'h010, A_VER = 12'h3F4;
  localparam logic [31:0] EN = 32'h4, IE = 32'h8, CED = 32'h20, CRST = 32'h4000_0000;
  localparam logic [31:0] CFG_A = 32'h00F0_0D00, CFG_B = 32'h0150_A300;
  localparam logic [31:0] RAW_A = 32'h1234_5678, RAW_B = 32'hCAFE_0F0F;

  always #5 clk = ~clk;

  rng_regif u_rng_regif (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .entropy_in(entropy_in),
    .seed_fault_inj(seed_fault_inj), .seed_fault_auto(seed_fault_auto),
    .clk_fault_inj(clk_fault_inj), .data_ready(data_ready), .irq(irq)
  );

  // expected conditioned word, restated from the requirement
  function automatic logic [31:0] expect_word(input logic [31:0] raw, input logic [31:0] ctrlw);
    logic [31:0] c, t;
    c = ((ctrlw >> 20) & 32'h3F) << 8 | ((ctrlw >> 8) & 32'hFF);
    t = raw ^ ((raw << 7) | (raw >> 25)) ^ (c << 18) ^ 32'h9E37_79B9;
    return (t == 0) ? 32'd1 : t;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic inject_seed(input logic auto_mode);
    @(negedge clk); seed_fault_inj = 1'b1; seed_fault_auto = auto_mode;
    @(posedge clk); #1 seed_fault_inj = 1'b0; seed_fault_auto = 1'b0;
  endtask

  // conditioning reset: request with config, release, wait for bit 30 to drop
  task automatic cond_reset(input logic [31:0] cfgw);
    logic [31:0] v;
    wr(A_CTRL, cfgw | CRST);
    wr(A_CTRL, cfgw & (EN | IE));
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); peek(A_CTRL, v);
      if (!v[30]) break;
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    peek(A_CTRL, v);   check("R1 ctrl reset", v, 32'h0);
    peek(A_STAT, v);   check("R1 status reset", v, 32'h0);
    peek(A_VER, v);    check("R1 version", v, 32'h21);
    check("R1 drdy/irq reset", {30'b0, data_ready, irq}, 32'h0);
    rd(A_DATA, v);     check("R8 empty read returns 0", v, 32'h0);
  endtask

  task automatic t_apply_config;
    logic [31:0] v;
    entropy_in = RAW_A;
    wr(A_CTRL, CFG_A | EN | CRST);
    peek(A_CTRL, v);   check("R5 bit30 reads 1 after request", {31'b0, v[30]}, 32'h1);
    wr(A_CTRL, EN);
    repeat (16) @(negedge clk);
    peek(A_CTRL, v);   check("R5 bit30 still 1 at clock 16", {31'b0, v[30]}, 32'h1);
    check("R5 drdy low in cycle", {31'b0, data_ready}, 32'h0);
    @(negedge clk);
    peek(A_CTRL, v);   check("R5 bit30 clear after cycle", {31'b0, v[30]}, 32'h0);
    check("R4 config latched with reset bit", v, 32'h00F0_0D04);
  endtask

  task automatic t_fifo_order;
    logic [31:0] v;
    repeat (8) @(negedge clk);
    check("R2 drdy with full fifo", {31'b0, data_ready}, 32'h1);
    entropy_in = RAW_B;
    for (int i = 0; i < 4; i++) begin
      rd(A_DATA, v); check("R3 older words first", v, expect_word(RAW_A, CFG_A));
    end
    rd(A_DATA, v);     check("R3 depth four then new word", v, expect_word(RAW_B, CFG_A));
  endtask

  task automatic t_ignore_config;
    logic [31:0] v;
    wr(A_CTRL, CFG_B | EN | CED | 32'h0003_0000);
    peek(A_CTRL, v);   check("R4 config ignored without reset bit", v, 32'h00F0_0D04);
    repeat (6) @(negedge clk);
    for (int i = 0; i < 5; i++) rd(A_DATA, v);
    check("R4 words keep latched config", v, expect_word(RAW_B, CFG_A));
  endtask

  task automatic t_flush;
    logic [31:0] v;
    repeat (6) @(negedge clk);
    wr(A_CTRL, CFG_A | EN | CRST);
    check("R5 drdy low on request", {31'b0, data_ready}, 32'h0);
    rd(A_DATA, v);     check("R8 read during reset returns 0", v, 32'h0);
    wr(A_CTRL, EN);
    repeat (17) @(negedge clk);
    check("R5 fifo flushed at end", {31'b0, data_ready}, 32'h0);
    @(negedge clk);
    check("R2 generation resumes", {31'b0, data_ready}, 32'h1);
  endtask

  task automatic t_divider;
    int n = 0;
    cond_reset(CFG_A | EN | 32'h0002_0000);
    while (!data_ready && n < 50) begin @(negedge clk); n++; end
    check("R12 first word on clock 4", n, 4);
    cond_reset(CFG_A | EN);
  endtask

  task automatic t_seed_sw;
    logic [31:0] v;
    repeat (6) @(negedge clk);
    inject_seed(1'b0);
    @(negedge clk); peek(A_STAT, v); check("R6 seed flags set, drdy low", v, 32'h44);
    rd(A_DATA, v);     check("R8 read after seed error returns 0", v, 32'h0);
    repeat (30) @(negedge clk);
    peek(A_STAT, v);   check("R6 current flag persists", v, 32'h44);
    wr(A_CTRL, EN | IE);
    @(negedge clk);
    check("R11 irq with ie and seis", {31'b0, irq}, 32'h1);
    wr(A_CTRL, EN);
    @(negedge clk);
    check("R11 irq masked", {31'b0, irq}, 32'h0);
    wr(A_STAT, 32'hFFFF_FFFF);
    @(negedge clk); peek(A_STAT, v); check("R10 writing 1 keeps flags", v, 32'h44);
    cond_reset(CFG_A | EN);
    peek(A_STAT, v);   check("R6 sw reset clears current flag", v & 32'h46, 32'h40);
    wr(A_STAT, 32'h0);
    @(negedge clk); peek(A_STAT, v); check("R10 writing 0 clears seis", v & 32'h40, 32'h0);
  endtask

  task automatic t_seed_auto;
    logic [31:0] v;
    inject_seed(1'b1);
    @(negedge clk); peek(A_CTRL, v); check("R7 no bit30 on auto", {31'b0, v[30]}, 32'h0);
    repeat (15) @(negedge clk);
    peek(A_STAT, v);   check("R7 current flag during recovery", v & 32'h44, 32'h44);
    @(negedge clk); peek(A_STAT, v); check("R7 self recovery signature", v & 32'h46, 32'h40);
    @(negedge clk);
    check("R7 generation resumes", {31'b0, data_ready}, 32'h1);
    wr(A_STAT, 32'h0);
  endtask

  task automatic t_clock_err;
    logic [31:0] v;
    @(negedge clk); clk_fault_inj = 1'b1;
    @(negedge clk); peek(A_STAT, v); check("R9 ignored without detect", v & 32'h22, 32'h0);
    clk_fault_inj = 1'b0;
    cond_reset(CFG_A | EN | CED);
    repeat (6) @(negedge clk);
    clk_fault_inj = 1'b1;
    @(negedge clk); peek(A_STAT, v); check("R9 clock error flags", v & 32'h22, 32'h22);
    for (int i = 0; i < 4; i++) rd(A_DATA, v);
    repeat (5) @(negedge clk);
    check("R9 generation stopped", {31'b0, data_ready}, 32'h0);
    clk_fault_inj = 1'b0;
    @(negedge clk); peek(A_STAT, v); check("R9 current clears, ceis kept", v & 32'h22, 32'h20);
    wr(A_STAT, 32'hFFFF_FFDF);
    @(negedge clk); peek(A_STAT, v); check("R10 ceis cleared by 0", v & 32'h20, 32'h0);
  endtask

  task automatic t_aux_regs;
    logic [31:0] v;
    wr(A_NOISE, 32'hFFFF_FFFF);
    peek(A_NOISE, v);  check("R13 noise control width", v, 32'h0003_FFFF);
    wr(A_HEALTH, 32'hA5A5_1234);
    peek(A_HEALTH, v); check("R13 health control", v, 32'hA5A5_1234);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_apply_config();
    t_fifo_order();
    t_ignore_config();
    t_flush();
    t_divider();
    t_seed_sw();
    t_seed_auto();
    t_clock_err();
    t_aux_regs();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule